// File: doc/BRIEF.md
# Sprite Collision Latch Array

This block records which of six graphics sources have overlapped on screen. On every clock one visible pixel is presented: six per-pixel enable bits (two players, two missiles, one ball and the playfield) together with a qualifier that marks the pixel as visible. For each of the 15 unordered pairs of sources there is one latch. A latch sets when both members of its pair are enabled on the same visible pixel, and it stays set until software clears it. The whole array is examined at pixel rate, alongside rendering, so software never has to test for overlaps itself.

The CPU reads the result through a small read port. A 3-bit address selects one of eight read words, and each word carries two latch bits in its top two data bits. One strobe input clears all 15 latches at once. If the strobe and a new overlap fall in the same clock, the strobe wins.

Top module: `sprite_collide_latches`

## Requirements
- R1: While `rst` is high, all 15 latches clear on the clock edge. After reset every read address returns 8'h00.
- R2: Source index order in `src_en` is bit 0 player 0, bit 1 player 1, bit 2 missile 0, bit 3 missile 1, bit 4 ball, bit 5 playfield. Pairs are numbered 0..14 by walking the first source i upward from 0 and, for each i, the second source j upward from i+1. So pair 0 is (0,1), pair 4 is (0,5), pair 5 is (1,2) and pair 14 is (4,5). Latch k sets on a clock edge where `pix_vis` is high and both sources of pair k are high.
- R3: A set latch stays set after its sources drop, until a clear or a reset.
- R4: When `pix_vis` is low, no latch changes, whatever `src_en` carries.
- R5: A clock with `clr_all` high resets all 15 latches on that edge.
- R6: When `clr_all` is high in the same clock as an overlap that would set a latch, the latch ends that edge cleared.
- R7: Read address a returns latch 2a on bit 7 and latch 2a+1 on bit 6. Bits 5..0 are always 0. At address 7, bit 6 has no latch behind it and reads 0.
- R8: `rd_data` is a combinational function of `rd_addr` and the latch state. A latch set on an edge is visible on the read port right after that edge, and an address change shows at once, with no clock.
- R9: Overlaps from different pixels accumulate. The latch state is the OR of all pairs set since the last clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_vis | input | 1 | Current pixel is visible |
| src_en | input | 6 | Per-pixel enables of the six sources |
| clr_all | input | 1 | Strobe that clears every latch |
| rd_addr | input | 3 | CPU read word select |
| rd_data | output | 8 | Read word: two latch bits in bits 7..6, zeros below |

## Verification
The clear strobe and the setting of a latch by a fresh overlap can land on the same edge. The bench provokes this by raising `clr_all` in the same clock as a visible pixel with all six sources enabled. It then reads all eight words and expects zero, which shows the clear winning. The same collision rule is also checked in a sweep over all 64 enable patterns, each preceded by a clear. That sweep judges that no stale bit survives the clear-then-set sequence.

// File: rtl/sprite_collide_pkg.sv
package sprite_collide_pkg;

    localparam int unsigned NUM_SRC  = 6;
    localparam int unsigned NUM_PAIR = NUM_SRC * (NUM_SRC - 1) / 2;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned NUM_WORD = (NUM_PAIR + 1) / 2;
    localparam int unsigned ADDR_W   = $clog2(NUM_WORD);
    localparam int unsigned PAD_W    = DATA_W - 2;

    typedef enum logic [2:0] {
        SRC_PLY0 = 3'd0,
        SRC_PLY1 = 3'd1,
        SRC_MSL0 = 3'd2,
        SRC_MSL1 = 3'd3,
        SRC_BALL = 3'd4,
        SRC_FIELD = 3'd5
    } src_id_e;

    typedef struct packed {
        logic             even_bit;
        logic             odd_bit;
        logic [PAD_W-1:0] pad;
    } rd_word_t;

    // First source of pair k in lexicographic (i<j) order.
    function automatic int unsigned pair_lo(input int unsigned k);
        int unsigned n;
        int unsigned res;
        n   = 0;
        res = 0;
        for (int unsigned i = 0; i < NUM_SRC; i++) begin
            for (int unsigned j = i + 1; j < NUM_SRC; j++) begin
                if (n == k) res = i;
                n++;
            end
        end
        return res;
    endfunction

    // Second source of pair k.
    function automatic int unsigned pair_hi(input int unsigned k);
        int unsigned n;
        int unsigned res;
        n   = 0;
        res = 0;
        for (int unsigned i = 0; i < NUM_SRC; i++) begin
            for (int unsigned j = i + 1; j < NUM_SRC; j++) begin
                if (n == k) res = j;
                n++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/sc_pair_detect.sv
module sc_pair_detect
    import sprite_collide_pkg::*;
(
    input  logic [NUM_SRC-1:0]  src_en,
    input  logic                pix_vis,
    output logic [NUM_PAIR-1:0] hit
);

    for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
        localparam int unsigned A_IDX = pair_lo(k);
        localparam int unsigned B_IDX = pair_hi(k);
        assign hit[k] = pix_vis & src_en[A_IDX] & src_en[B_IDX];
    end

endmodule

// File: rtl/sc_latch_bank.sv
module sc_latch_bank
    import sprite_collide_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_all,
    input  logic                pix_vis,
    input  logic [NUM_PAIR-1:0] hit,
    output logic [NUM_PAIR-1:0] lat_q
);

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_q | hit;
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (lat_q == '0));

    p_set_r2: assert property (@(posedge clk) disable iff (rst)
        (!clr_all && (hit != '0)) |=> ((lat_q & $past(hit)) == $past(hit)));

    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        !clr_all |=> ((lat_q & $past(lat_q)) == $past(lat_q)));

    p_novis_r4: assert property (@(posedge clk) disable iff (rst)
        (!pix_vis && !clr_all) |=> $stable(lat_q));

    p_clear_wins_r6: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (lat_q == '0));

endmodule

// File: rtl/sc_read_mux.sv
module sc_read_mux
    import sprite_collide_pkg::*;
(
    input  logic [NUM_PAIR-1:0] lat_q,
    input  logic [ADDR_W-1:0]   rd_addr,
    output rd_word_t            word
);

    logic [2*NUM_WORD-1:0] padded;

    assign padded = {{(2*NUM_WORD-NUM_PAIR){1'b0}}, lat_q};

    always_comb begin
        word          = '0;
        word.even_bit = padded[2*rd_addr];
        word.odd_bit  = padded[2*rd_addr+1];
    end

endmodule

// File: rtl/sprite_collide_latches.sv
module sprite_collide_latches
    import sprite_collide_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_vis,
    input  logic [5:0]        src_en,
    input  logic              clr_all,
    input  logic [2:0]        rd_addr,
    output logic [7:0]        rd_data
);

    logic [NUM_PAIR-1:0] hit;
    logic [NUM_PAIR-1:0] lat_q;
    rd_word_t            word;

    sc_pair_detect u_detect (
        .src_en  (src_en),
        .pix_vis (pix_vis),
        .hit     (hit)
    );

    sc_latch_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .clr_all (clr_all),
        .pix_vis (pix_vis),
        .hit     (hit),
        .lat_q   (lat_q)
    );

    sc_read_mux u_rdmux (
        .lat_q   (lat_q),
        .rd_addr (rd_addr),
        .word    (word)
    );

    assign rd_data = word;

    p_pad_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_data[5:0] == '0) && !(rd_addr == 3'd7 && rd_data[6]));

endmodule

// File: tb/sprite_collide_latches_tb.sv
module sprite_collide_latches_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       pix_vis;
    logic [5:0] src_en;
    logic       clr_all;
    logic [2:0] rd_addr;
    logic [7:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    logic [15:0] exp_lat;

    sprite_collide_latches u_dut (
        .clk     (clk),
        .rst     (rst),
        .pix_vis (pix_vis),
        .src_en  (src_en),
        .clr_all (clr_all),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always #4 clk = ~clk;

    // Pairs for one enable pattern, numbered by walking i up, then j>i up.
    function automatic logic [15:0] pairs_of(input logic [5:0] en);
        logic [15:0] r;
        int n;
        r = '0;
        n = 0;
        for (int i = 0; i < 6; i++) begin
            for (int j = i + 1; j < 6; j++) begin
                r[n] = en[i] & en[j];
                n++;
            end
        end
        return r;
    endfunction

    task automatic cycle(input logic vis, input logic [5:0] en, input logic clr);
        @(negedge clk);
        pix_vis = vis;
        src_en  = en;
        clr_all = clr;
        @(posedge clk);
        #1;
        @(negedge clk);
        pix_vis = 1'b0;
        src_en  = '0;
        clr_all = 1'b0;
    endtask

    task automatic read_all(input logic [15:0] lat, input string req);
        for (int a = 0; a < 8; a++) begin
            logic [7:0] want;
            rd_addr = a[2:0];
            #1;
            want = {lat[2*a], lat[2*a+1], 6'b0};
            checks++;
            if (rd_data !== want) begin
                errors++;
                $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, rd_data, want);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pix_vis = 1'b0; src_en = '0; clr_all = 1'b0; rd_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        read_all(16'h0, "R1 reset");

        // R2 R7 R3 R8: all 64 patterns, read after sources dropped
        for (int p = 0; p < 64; p++) begin
            cycle(1'b0, 6'h0, 1'b1);
            cycle(1'b1, p[5:0], 1'b0);
            cycle(1'b0, 6'h0, 1'b0);
            read_all(pairs_of(p[5:0]), "R2/R3/R7/R8 sweep");
        end

        // R4: invisible pixels never set
        cycle(1'b0, 6'h0, 1'b1);
        cycle(1'b0, 6'h3f, 1'b0);
        cycle(1'b0, 6'h15, 1'b0);
        read_all(16'h0, "R4 invisible");

        // R5: clear alone
        cycle(1'b1, 6'h3f, 1'b0);
        read_all(16'h7fff, "R5 before clear");
        cycle(1'b0, 6'h0, 1'b1);
        read_all(16'h0, "R5 after clear");

        // R6: clear and overlap in the same clock
        cycle(1'b1, 6'h3f, 1'b0);
        cycle(1'b1, 6'h3f, 1'b1);
        read_all(16'h0, "R6 clear wins");

        // R9: accumulation across pixels
        cycle(1'b1, 6'b000011, 1'b0);
        cycle(1'b1, 6'b110000, 1'b0);
        exp_lat = pairs_of(6'b000011) | pairs_of(6'b110000);
        read_all(exp_lat, "R9 accumulate");
        cycle(1'b1, 6'b000101, 1'b0);
        exp_lat = exp_lat | pairs_of(6'b000101);
        read_all(exp_lat, "R9 accumulate third");

        // R1: reset mid-run clears
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        read_all(16'h0, "R1 reset after use");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule